// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block produces the six status flags that follow an arithmetic or logic operation: carry, parity, auxiliary (half) carry, zero, sign and signed overflow. It sits beside an ALU and observes the ALU's inputs and result without computing the result itself. Each operation arrives as a class (move, add, subtract, logic), an operand size (8, 16 or 32 bits), the two operands, the incoming carry or borrow, and the result the ALU produced.

When a valid operation of an arithmetic or logic class is presented, the flags are evaluated at the chosen operand size and captured on the next rising clock edge. Two write-enable outputs accompany the captured flags for one cycle. One covers the result group (zero, sign, parity) and the other covers the carry group (carry, auxiliary carry, overflow), so a downstream flag register can merge them. Data moves and idle cycles leave every flag untouched.

Top module: `status_flag_unit`

## Requirements
- R1: While rstN is low, all six flag outputs and both write enables are 0.
- R2: For an add (opClass 1) flagCarry is the carry out of the top bit of opA + opB + carryIn at the operand size; for a subtract (opClass 2) it is 1 when opA - opB - carryIn borrows at that size.
- R3: flagOverflow for an add is 1 when the operand sign bits agree and the result sign bit differs from opA's; for a subtract it is 1 when the operand sign bits differ and the result sign bit differs from opA's.
- R4: For add and subtract, flagAux equals bit 4 of opA XOR opB XOR result, the carry or borrow between bits 3 and 4.
- R5: flagParity is 1 when bits 7..0 of the result hold an even number of ones and 0 when odd, at every operand size.
- R6: flagZero is 1 when the result bits inside the operand size are all zero; result bits above the size are ignored.
- R7: flagSign equals the top result bit inside the operand size.
- R8: opSize 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits, and 3 is treated as 32 bits.
- R9: A logic operation (opClass 3) clears flagCarry, flagAux and flagOverflow and sets parity, zero and sign from the result.
- R10: A data move (opClass 0) or a cycle with opValid low leaves all six flags unchanged and both write enables at 0 in the following cycle.
- R11: Flags take their new values on the first rising edge with opValid high, and weResult and weCarry are 1 for exactly the cycle after each valid add, subtract or logic operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe |
| opClass | input | 2 | 0 move, 1 add, 2 subtract, 3 logic |
| opSize | input | 2 | 0 byte, 1 16-bit, 2 and 3 32-bit |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| carryIn | input | 1 | Incoming carry (add) or borrow (subtract) |
| result | input | 32 | Result produced by the ALU |
| flagCarry | output | 1 | Carry or borrow flag |
| flagParity | output | 1 | Even parity of low result byte |
| flagAux | output | 1 | Half carry between bits 3 and 4 |
| flagZero | output | 1 | Result is zero at operand size |
| flagSign | output | 1 | Top result bit at operand size |
| flagOverflow | output | 1 | Signed overflow |
| weResult | output | 1 | Zero, sign and parity were written |
| weCarry | output | 1 | Carry, auxiliary and overflow were written |

## Verification
The assertions assume opClass, opSize, operands and result carry known values whenever opValid is high, and that a zero result implies a clear sign bit and even low-byte parity, which holds for any real result because a zero word has neither. The overflow property depends only on sign bits, so it holds whether or not the result matches the operands. The bench keeps to this by driving every operation with a result that a correct ALU would produce at the chosen size, setting the unused upper result bits to arbitrary values only where the size masking is itself under test.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [1:0] {
    OP_MOVE  = 2'd0,
    OP_ADD   = 2'd1,
    OP_SUB   = 2'd2,
    OP_LOGIC = 2'd3
  } opClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadResult;
    logic loadCarry;
    logic isSub;
    logic isLogic;
  } flagCtrl_t;

  typedef struct packed {
    logic carry;
    logic parity;
    logic aux;
    logic zero;
    logic sign;
    logic overflow;
  } flagSet_t;

endpackage

// File: rtl/sfg_control.sv
module sfg_control
  import sfg_pkg::*;
#(
  parameter int NUM_SIZES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [1:0] opClass,
  input  logic [1:0] opSize,
  output flagCtrl_t  ctrl,
  output logic [1:0] laneSel,
  output logic       weResult,
  output logic       weCarry
);

  localparam logic [1:0] TOP_LANE = 2'(NUM_SIZES - 1);

  opClass_e cls;
  logic     doWrite;

  assign cls     = opClass_e'(opClass);
  assign doWrite = opValid && (cls != OP_MOVE);

  always_comb begin
    ctrl.loadResult = doWrite;
    ctrl.loadCarry  = doWrite;
    ctrl.isSub      = (cls == OP_SUB);
    ctrl.isLogic    = (cls == OP_LOGIC);
  end

  // sizes beyond the widest lane fall back to the widest lane
  assign laneSel = (opSize > TOP_LANE) ? TOP_LANE : opSize;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weResult <= 1'b0;
      weCarry  <= 1'b0;
    end else begin
      weResult <= ctrl.loadResult;
      weCarry  <= ctrl.loadCarry;
    end
  end

endmodule

// File: rtl/sfg_datapath.sv
module sfg_datapath
  import sfg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SIZES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCtrl_t         ctrl,
  input  logic [1:0]        laneSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] result,
  output flagSet_t          flags
);

  logic [NUM_SIZES-1:0] laneAddCarry;
  logic [NUM_SIZES-1:0] laneSubBorrow;
  logic [NUM_SIZES-1:0] laneAddOvf;
  logic [NUM_SIZES-1:0] laneSubOvf;
  logic [NUM_SIZES-1:0] laneZero;
  logic [NUM_SIZES-1:0] laneSign;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int W = 8 << k;
    logic [W:0] sumExt;
    logic [W:0] subtrahend;
    logic       aTop;
    logic       bTop;
    logic       rTop;

    assign sumExt     = {1'b0, opA[W-1:0]} + {1'b0, opB[W-1:0]} + {{W{1'b0}}, carryIn};
    assign subtrahend = {1'b0, opB[W-1:0]} + {{W{1'b0}}, carryIn};
    assign aTop       = opA[W-1];
    assign bTop       = opB[W-1];
    assign rTop       = result[W-1];

    assign laneAddCarry[k]  = (sumExt > {1'b0, {W{1'b1}}});
    assign laneSubBorrow[k] = ({1'b0, opA[W-1:0]} < subtrahend);
    assign laneAddOvf[k]    = (aTop == bTop) && (rTop != aTop);
    assign laneSubOvf[k]    = (aTop != bTop) && (rTop != aTop);
    assign laneZero[k]      = (result[W-1:0] == '0);
    assign laneSign[k]      = rTop;
  end

  flagSet_t nextFlags;
  logic     halfCarry;

  assign halfCarry = opA[4] ^ opB[4] ^ result[4];

  always_comb begin
    nextFlags.parity   = ~^result[7:0];
    nextFlags.zero     = laneZero[laneSel];
    nextFlags.sign     = laneSign[laneSel];
    nextFlags.carry    = ctrl.isSub ? laneSubBorrow[laneSel] : laneAddCarry[laneSel];
    nextFlags.overflow = ctrl.isSub ? laneSubOvf[laneSel]    : laneAddOvf[laneSel];
    nextFlags.aux      = halfCarry;
    if (ctrl.isLogic) begin
      nextFlags.carry    = 1'b0;
      nextFlags.overflow = 1'b0;
      nextFlags.aux      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
    end else begin
      if (ctrl.loadResult) begin
        flags.parity <= nextFlags.parity;
        flags.zero   <= nextFlags.zero;
        flags.sign   <= nextFlags.sign;
      end
      if (ctrl.loadCarry) begin
        flags.carry    <= nextFlags.carry;
        flags.aux      <= nextFlags.aux;
        flags.overflow <= nextFlags.overflow;
      end
    end
  end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [1:0]        opClass,
  input  logic [1:0]        opSize,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] result,
  output logic              flagCarry,
  output logic              flagParity,
  output logic              flagAux,
  output logic              flagZero,
  output logic              flagSign,
  output logic              flagOverflow,
  output logic              weResult,
  output logic              weCarry
);

  localparam int NUM_SIZES = $clog2(DATA_W / 8) + 1;

  flagCtrl_t  ctrl;
  logic [1:0] laneSel;
  flagSet_t   flags;

  sfg_control #(.NUM_SIZES(NUM_SIZES)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .opValid  (opValid),
    .opClass  (opClass),
    .opSize   (opSize),
    .ctrl     (ctrl),
    .laneSel  (laneSel),
    .weResult (weResult),
    .weCarry  (weCarry)
  );

  sfg_datapath #(.DATA_W(DATA_W), .NUM_SIZES(NUM_SIZES)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .laneSel (laneSel),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .result  (result),
    .flags   (flags)
  );

  assign flagCarry    = flags.carry;
  assign flagParity   = flags.parity;
  assign flagAux      = flags.aux;
  assign flagZero     = flags.zero;
  assign flagSign     = flags.sign;
  assign flagOverflow = flags.overflow;

endmodule

// File: rtl/sfg_checker.sv
module sfg_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [1:0]        opClass,
  input logic [1:0]        opSize,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [DATA_W-1:0] result,
  input logic              flagCarry,
  input logic              flagParity,
  input logic              flagAux,
  input logic              flagZero,
  input logic              flagSign,
  input logic              flagOverflow,
  input logic              weResult,
  input logic              weCarry
);

  logic [5:0] allFlags;
  assign allFlags = {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};

  assert_move_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd0) |=> ($stable(allFlags) && !weResult && !weCarry));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> ($stable(allFlags) && !weResult && !weCarry));

  assert_we_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass != 2'd0) |=> (weResult && weCarry));

  assert_logic_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd3) |=> (!flagCarry && !flagAux && !flagOverflow));

  assert_byte_ovf_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opClass == 2'd1 && opSize == 2'd0) |=>
      (flagOverflow == $past((opA[7] == opB[7]) && (result[7] != opA[7]))));

  assert_zero_parity_R5: assert property (@(posedge clk) disable iff (!rstN)
    flagZero |-> flagParity);

  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    flagZero |-> !flagSign);

endmodule

bind status_flag_unit sfg_checker #(.DATA_W(DATA_W)) u_sfg_checker (
  .clk          (clk),
  .rstN         (rstN),
  .opValid      (opValid),
  .opClass      (opClass),
  .opSize       (opSize),
  .opA          (opA),
  .opB          (opB),
  .result       (result),
  .flagCarry    (flagCarry),
  .flagParity   (flagParity),
  .flagAux      (flagAux),
  .flagZero     (flagZero),
  .flagSign     (flagSign),
  .flagOverflow (flagOverflow),
  .weResult     (weResult),
  .weCarry      (weCarry)
);

// File: tb/status_flag_unit_bench.sv
module status_flag_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VECS   = 10;

  // {class[2], size[2], a[32], b[32], cin, result[32], exp {C,P,A,Z,S,O}}
  localparam logic [106:0] VECS [NUM_VECS] = '{
    {2'd1, 2'd0, 32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0000, 6'b111100},
    {2'd1, 2'd0, 32'h0000_007F, 32'h0000_0001, 1'b0, 32'h0000_0080, 6'b001011},
    {2'd2, 2'd0, 32'h0000_0000, 32'h0000_0001, 1'b0, 32'h0000_00FF, 6'b111010},
    {2'd2, 2'd0, 32'h0000_0080, 32'h0000_0001, 1'b0, 32'h0000_007F, 6'b001001},
    {2'd1, 2'd1, 32'h0000_00FF, 32'h0000_0001, 1'b0, 32'h0000_0100, 6'b011000},
    {2'd1, 2'd1, 32'h0000_FFFF, 32'h0000_0001, 1'b0, 32'hABCD_0000, 6'b111100},
    {2'd1, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 32'h8000_0000, 6'b011011},
    {2'd2, 2'd2, 32'h0000_0005, 32'h0000_0003, 1'b1, 32'h0000_0001, 6'b000000},
    {2'd1, 2'd2, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 32'h0000_0000, 6'b111100},
    {2'd2, 2'd1, 32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_FFFF, 6'b111010}
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [1:0]  opClass;
  logic [1:0]  opSize;
  logic [31:0] opA;
  logic [31:0] opB;
  logic        carryIn;
  logic [31:0] result;
  logic        flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow;
  logic        weResult, weCarry;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  status_flag_unit u_status_flag_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opClass(opClass), .opSize(opSize),
    .opA(opA), .opB(opB), .carryIn(carryIn), .result(result),
    .flagCarry(flagCarry), .flagParity(flagParity), .flagAux(flagAux),
    .flagZero(flagZero), .flagSign(flagSign), .flagOverflow(flagOverflow),
    .weResult(weResult), .weCarry(weCarry)
  );

  function automatic logic [5:0] curFlags();
    return {flagCarry, flagParity, flagAux, flagZero, flagSign, flagOverflow};
  endfunction

  task automatic checkVal(input logic [31:0] actual, input logic [31:0] expected,
                          input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // per-flag checks, each under its own requirement
  task automatic checkFlags(input logic [5:0] exp, input string where);
    checkVal({31'd0, flagCarry},    {31'd0, exp[5]}, {"R2 carry ", where});
    checkVal({31'd0, flagParity},   {31'd0, exp[4]}, {"R5 parity ", where});
    checkVal({31'd0, flagAux},      {31'd0, exp[3]}, {"R4 aux ", where});
    checkVal({31'd0, flagZero},     {31'd0, exp[2]}, {"R6 zero ", where});
    checkVal({31'd0, flagSign},     {31'd0, exp[1]}, {"R7 sign ", where});
    checkVal({31'd0, flagOverflow}, {31'd0, exp[0]}, {"R3 overflow ", where});
  endtask

  task automatic drive(input logic v, input logic [1:0] c, input logic [1:0] s,
                       input logic [31:0] a, input logic [31:0] b, input logic ci,
                       input logic [31:0] r);
    opValid = v; opClass = c; opSize = s; opA = a; opB = b; carryIn = ci; result = r;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(1'b1, 2'd1, 2'd0, 32'hFF, 32'h01, 1'b0, 32'h0);
    repeat (3) @(negedge clk);
    checkVal({26'd0, curFlags()}, 32'd0, "R1 flags in reset");
    checkVal({30'd0, weResult, weCarry}, 32'd0, "R1 enables in reset");
    drive(1'b0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk
    for (int i = 0; i < NUM_VECS; i++) begin
      drive(1'b1, VECS[i][106:105], VECS[i][104:103], VECS[i][102:71],
            VECS[i][70:39], VECS[i][38], VECS[i][37:6]);
      @(negedge clk);
      checkFlags(VECS[i][5:0], $sformatf("vec %0d", i));
      checkVal({30'd0, weResult, weCarry}, 32'd3, "R11 enables after op");
      drive(1'b0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);
    end

    // R11: enables last one cycle
    @(negedge clk);
    checkVal({30'd0, weResult, weCarry}, 32'd0, "R11 enables drop");

    // R9: logic OR byte, after aux was left set
    drive(1'b1, 2'd1, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b1, 32'h0); // sets C,A
    @(negedge clk);
    drive(1'b1, 2'd3, 2'd0, 32'hF0, 32'h0F, 1'b0, 32'hFF);
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b010010}, "R9 logic byte flags");
    drive(1'b1, 2'd3, 2'd2, 32'hF0, 32'h0F, 1'b0, 32'h0);
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b010100}, "R9 logic zero flags");

    // R10: move leaves flags
    drive(1'b1, 2'd0, 2'd0, 32'hFF, 32'h01, 1'b1, 32'h81);
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b010100}, "R10 move holds flags");
    checkVal({30'd0, weResult, weCarry}, 32'd0, "R10 move enables low");

    // R10: idle with add pattern present
    drive(1'b0, 2'd1, 2'd0, 32'h7F, 32'h01, 1'b0, 32'h80);
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b010100}, "R10 idle holds flags");
    checkVal({30'd0, weResult, weCarry}, 32'd0, "R10 idle enables low");

    // R8: size code 3 behaves as 32 bits
    drive(1'b1, 2'd1, 2'd3, 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h0);
    #1;
    checkVal({26'd0, curFlags()}, {26'd0, 6'b010100}, "R11 no change before edge");
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b110101}, "R8 size 3 as 32-bit");

    // R8: byte size ignores upper operand bits for carry
    drive(1'b1, 2'd1, 2'd0, 32'hFFFF_FF01, 32'h8000_0001, 1'b0, 32'h0000_0002);
    @(negedge clk);
    checkVal({26'd0, curFlags()}, {26'd0, 6'b000000}, "R8 byte lane masks upper bits");
    drive(1'b0, 2'd0, 2'd0, 32'h0, 32'h0, 1'b0, 32'h0);

    // R1: reset clears after activity
    rstN = 1'b0;
    @(negedge clk);
    checkVal({26'd0, curFlags()}, 32'd0, "R1 flags after reset");
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule